// File: doc/BRIEF.md
# Serial DAC Command Receiver with Two-Stage Latch

This block receives command words for a 12-bit digital-to-analog converter over a receive-only SPI link. The bus master lowers the frame select, clocks in one 16-bit word most significant bit first, and then raises the select again. The block samples the serial line on each rising serial clock edge. When the select rises after a complete word has arrived, the word is committed to an internal input register. A frame that ends early is thrown away.

A separate active-low load strobe moves the input register into the output register, and the output register drives the converter. The transfer is level-sensitive. While the strobe is low, the output follows the input register one system clock later. While the strobe is high, the output holds its value. All four serial-side pins are asynchronous to the system clock. They pass through a synchronizer, and their edges are found in the system clock domain, which must run at least four times faster than the serial clock.

Top module: `dac_cmd_rx`

## Requirements
- R1: A command word is 16 bits, sent most significant bit first. The upper 4 bits (word bits 15..12) appear on `dac_cfg`, and the lower 12 bits (word bits 11..0) appear on `dac_code`.
- R2: The serial data line is sampled on the rising edge of `spi_sck`. This works both when the clock idles low (mode 0) and when it idles high (mode 3).
- R3: While `spi_cs_n` is high, serial clock edges shift nothing into the block, and the stored word does not change.
- R4: When `spi_cs_n` rises after at least 16 rising `spi_sck` edges, the received word is written to the input register.
- R5: When `spi_cs_n` rises after fewer than 16 rising edges, the frame is dropped and the input register keeps its previous value.
- R6: Rising `spi_sck` edges after the 16th within one select-low window are ignored, so the first 16 bits are the ones kept.
- R7: While `load_n` (after synchronization) is low, the output register takes the input register value on every system clock. While it is high, the output register holds.
- R8: Reset clears the input register and the output register to zero, so `dac_cfg` and `dac_code` read 0.
- R9: A falling edge of `spi_cs_n` clears the bit count. A full frame that follows an aborted frame is therefore received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the bus master |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_sdi | input | 1 | Serial data in, most significant bit first |
| load_n | input | 1 | Active-low, level-sensitive transfer strobe into the output register |
| dac_cfg | output | 4 | Configuration field of the output register |
| dac_code | output | 12 | Converter data field of the output register |

## Verification
Two functions can fall in the same cycle: committing a new word at the rise of the select, and the load transfer into the output register. The bench holds `load_n` low for the whole of a frame, so the commit happens while the transfer is active. It then expects the new word on the outputs a few cycles after the select rises, with no pulse on the strobe. In a separate case, `load_n` stays high through a frame and the bench expects the outputs to keep the old word. This shows the two paths are really separate stages.

// File: rtl/dac_rx_pkg.sv
package dac_rx_pkg;

   // Frame receive phase, derived from select level and bit count
   typedef enum logic [1:0] {
      FR_IDLE  = 2'd0,
      FR_SHIFT = 2'd1,
      FR_FULL  = 2'd2
   } frame_st_e;

   // Width of a counter that must reach n inclusive
   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/dac_rx_sync.sv
module dac_rx_sync #(
   parameter int unsigned       W       = 4,
   parameter int unsigned       STAGES  = 2,
   parameter logic [W-1:0]      RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("dac_rx_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("dac_rx_sync: W must be at least 1");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stg
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/dac_rx_frame.sv
module dac_rx_frame
   import dac_rx_pkg::*;
#(
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_s,
   input  logic              cs_n_s,
   input  logic              sdi_s,
   output logic [WORD_W-1:0] word,
   output logic              commit
);

   localparam int unsigned CNT_W = cnt_width(WORD_W);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

   if (WORD_W < 2) begin : g_bad_word
      $error("dac_rx_frame: WORD_W must be at least 2");
   end

   logic             sck_q, cs_q;
   logic             sck_rise, cs_fall, cs_rise;
   logic [CNT_W-1:0] cnt;
   logic [WORD_W-1:0] shreg;
   frame_st_e        st;
   logic             shift_en;

   // one extra register per line for edge detection
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_q <= 1'b0;
         cs_q  <= 1'b1;
      end else begin
         sck_q <= sck_s;
         cs_q  <= cs_n_s;
      end
   end

   assign sck_rise = sck_s & ~sck_q;
   assign cs_fall  = ~cs_n_s & cs_q;
   assign cs_rise  = cs_n_s & ~cs_q;

   always_comb begin
      if (cs_n_s)              st = FR_IDLE;
      else if (cnt == CNT_FULL) st = FR_FULL;
      else                     st = FR_SHIFT;
   end

   assign shift_en = (st == FR_SHIFT) && sck_rise && !cs_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         shreg <= '0;
      end else if (cs_fall) begin
         cnt   <= '0;
      end else if (shift_en) begin
         cnt   <= cnt + 1'b1;
         shreg <= {shreg[WORD_W-2:0], sdi_s};
      end
   end

   assign word   = shreg;
   assign commit = cs_rise && (cnt == CNT_FULL);

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_FULL);                                            // R6
   AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> $stable(shreg));                                  // R3
   AST_FULL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == CNT_FULL && !cs_fall) |=> $stable(shreg));           // R6
   AST_CLEAR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      cs_fall |=> (cnt == '0));                                    // R9
   AST_COMMIT_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (cs_n_s && !cs_q));                               // R4

endmodule

// File: rtl/dac_rx_latch.sv
module dac_rx_latch #(
   parameter int unsigned WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_word,
   input  logic              load_n_s,
   output logic [WORD_W-1:0] out_q
);

   logic [WORD_W-1:0] in_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     in_q <= '0;
      else if (wr_en) in_q <= wr_word;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         out_q <= '0;
      else if (!load_n_s) out_q <= in_q;
   end

   AST_COMMIT_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (in_q == $past(wr_word)));                         // R4
   AST_DROP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(in_q));                                   // R5
   AST_LOAD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      !load_n_s |=> (out_q == $past(in_q)));                       // R7
   AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      load_n_s |=> $stable(out_q));                                // R7

endmodule

// File: rtl/dac_cmd_rx.sv
module dac_cmd_rx #(
   parameter int unsigned CFG_W       = 4,
   parameter int unsigned DATA_W      = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_cs_n,
   input  logic              spi_sdi,
   input  logic              load_n,
   output logic [CFG_W-1:0]  dac_cfg,
   output logic [DATA_W-1:0] dac_code
);

   localparam int unsigned WORD_W = CFG_W + DATA_W;
   // synchronizer bundle: {load_n, sdi, cs_n, sck}
   localparam logic [3:0]  SYNC_RST = 4'b1010;

   if (CFG_W < 1 || DATA_W < 1) begin : g_bad_fields
      $error("dac_cmd_rx: CFG_W and DATA_W must be at least 1");
   end

   logic [3:0]        pins_s;
   logic [WORD_W-1:0] rx_word;
   logic              rx_commit;
   logic [WORD_W-1:0] out_word;

   dac_rx_sync #(
      .W       (4),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (SYNC_RST)
   ) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .d_async ({load_n, spi_sdi, spi_cs_n, spi_sck}),
      .q       (pins_s)
   );

   dac_rx_frame #(
      .WORD_W (WORD_W)
   ) i_frame (
      .clk    (clk),
      .rst_n  (rst_n),
      .sck_s  (pins_s[0]),
      .cs_n_s (pins_s[1]),
      .sdi_s  (pins_s[2]),
      .word   (rx_word),
      .commit (rx_commit)
   );

   dac_rx_latch #(
      .WORD_W (WORD_W)
   ) i_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (rx_commit),
      .wr_word  (rx_word),
      .load_n_s (pins_s[3]),
      .out_q    (out_word)
   );

   assign dac_cfg  = out_word[WORD_W-1 -: CFG_W];
   assign dac_code = out_word[DATA_W-1:0];

   AST_FIELDS_STILL: assert property (@(posedge clk) disable iff (!rst_n)
      pins_s[3] |=> ($stable(dac_cfg) && $stable(dac_code)));      // R1

endmodule

// File: tb/test_dac_cmd_rx.sv
`timescale 1ns/1ps
module test_dac_cmd_rx;

   typedef struct {
      logic [15:0] word;
      string       req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        spi_sck = 1'b0;
   logic        spi_cs_n = 1'b1;
   logic        spi_sdi = 1'b0;
   logic        load_n = 1'b1;
   logic [3:0]  dac_cfg;
   logic [11:0] dac_code;

   int          n_chk = 0;
   int          n_fail = 0;
   bit          done = 1'b0;
   logic [15:0] model_in = '0;
   exp_t        sb_q[$];
   event        ev_cmp;

   always #2.5 clk = ~clk;

   dac_cmd_rx i_dac_cmd_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .spi_sck  (spi_sck),
      .spi_cs_n (spi_cs_n),
      .spi_sdi  (spi_sdi),
      .load_n   (load_n),
      .dac_cfg  (dac_cfg),
      .dac_code (dac_code)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // monitor: pops expected items and compares at a falling edge
   initial begin
      forever begin
         @(ev_cmp);
         @(negedge clk);
         while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.req, {dac_cfg, dac_code}, e.word);
         end
      end
   end

   task automatic expect_out(input logic [15:0] w, input string req);
      exp_t e;
      e.word = w;
      e.req  = req;
      sb_q.push_back(e);
      ->ev_cmp;
      repeat (2) @(negedge clk);
   endtask

   task automatic send_frame(input logic [15:0] w, input int nbits, input bit mode3);
      spi_sck = mode3;
      #20;
      spi_cs_n = 1'b0;
      #40;
      for (int i = 0; i < nbits; i++) begin
         spi_sck = 1'b0;
         spi_sdi = (i < 16) ? w[15-i] : ~w[i%16];
         #20;
         spi_sck = 1'b1;
         #20;
      end
      spi_sck = mode3;
      #20;
      spi_cs_n = 1'b1;
      #60;
      if (nbits >= 16) model_in = w;
   endtask

   task automatic pulse_load();
      load_n = 1'b0;
      #20;
      load_n = 1'b1;
      #40;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      expect_out(16'h0000, "R8 reset state");

      // full frame, mode 0
      send_frame(16'hA5C3, 16, 1'b0);
      pulse_load();
      expect_out(model_in, "R1 R4 mode0 full frame");
      check("R1 cfg field", {12'h0, dac_cfg}, 16'h000A);

      // full frame, mode 3
      send_frame(16'h3E71, 16, 1'b1);
      pulse_load();
      expect_out(16'h3E71, "R2 mode3 full frame");

      // short frame dropped
      send_frame(16'hFFFF, 10, 1'b0);
      pulse_load();
      expect_out(16'h3E71, "R5 short frame dropped");

      // long frame, extra clocks ignored
      send_frame(16'h1234, 20, 1'b0);
      pulse_load();
      expect_out(16'h1234, "R6 extra clocks ignored");

      // clocks with select high
      for (int k = 0; k < 20; k++) begin
         spi_sdi = k[0];
         spi_sck = 1'b0; #20;
         spi_sck = 1'b1; #20;
      end
      spi_sck = 1'b0;
      #40;
      pulse_load();
      expect_out(16'h1234, "R3 clocks while deselected");

      // aborted then full frame
      send_frame(16'h0F0F, 7, 1'b1);
      send_frame(16'hC0DE, 16, 1'b1);
      pulse_load();
      expect_out(16'hC0DE, "R9 frame after abort");

      // strobe high: output holds across a commit
      send_frame(16'h8001, 16, 1'b0);
      expect_out(16'hC0DE, "R7 hold while strobe high");
      pulse_load();
      expect_out(16'h8001, "R7 transfer on strobe");

      // strobe held low during commit
      load_n = 1'b0;
      #40;
      send_frame(16'h7FFE, 16, 1'b0);
      expect_out(16'h7FFE, "R7 commit while strobe low");
      send_frame(16'h5555, 3, 1'b0);
      expect_out(16'h7FFE, "R5 short frame while strobe low");
      send_frame(16'h0ABC, 16, 1'b1);
      expect_out(16'h0ABC, "R2 R7 mode3 commit while strobe low");
      load_n = 1'b1;
      #40;

      // reset again clears both stages
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      check("R8 reset clears output", {dac_cfg, dac_code}, 16'h0000);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      pulse_load();
      expect_out(16'h0000, "R8 reset clears input register");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule